// File: doc/BRIEF.md
# Serial Setpoint Frame Transmitter

This block sends one signed 16-bit corrector current setpoint at a time over a one-way serial line to a power supply. An external line driver turns the single-ended output into a differential pair. Nothing ever comes back over the link, so there is no acknowledgement or retry.

A setpoint is offered with a one-cycle load strobe. The block wraps the word in a fixed 22-bit frame made of synchronization bits, the payload, and two parity bits. It shifts the frame out at a bit period set by a run-time clock divider. A 100 MHz clock with a divider of 80 gives 1.25 Mbit/s, so a whole frame takes 17.6 µs. That is inside the 20 µs budget for delivering a setpoint.

A strobe that arrives while a frame is on the line is held in a single slot. That word goes out right after the current frame ends, with no idle gap in between.

Top module: `setpoint_frame_tx`

## Requirements
- R1: While `rst_ni` is low, and from the moment it goes low, `line_o` is 1, `busy_o` is 0 and `done_o` is 0. A word held for later is discarded by reset.
- R2: Whenever `busy_o` is 0, `line_o` is 1, whatever `data_i` and `bit_div_i` do.
- R3: A frame is 22 bits, sent in this order: two start bits at 0, then `data_i[15]` (the sign) down to `data_i[0]`, then the upper-byte parity bit, then the lower-byte parity bit, then two stop bits at 1.
- R4: Each parity bit is the XOR of the eight bits of its byte, so that byte and its parity bit together hold an even number of ones.
- R5: Every frame bit stays on `line_o` for exactly D clock cycles. D is `bit_div_i` as sampled on the edge where the frame starts. A frame therefore lasts 22·D cycles.
- R6: A `bit_div_i` value of 0 or 1 is treated as 2.
- R7: When `load_i` is 1 at a clock edge while `busy_o` is 0, the frame for `data_i` starts on that edge. `busy_o` is 1 and the first start bit is on `line_o` in the following cycle.
- R8: When `load_i` is 1 while `busy_o` is 1, `data_i` is held. A later strobe during the same frame replaces the held word. The held word's frame starts on the edge that ends the current frame, using `bit_div_i` from that edge, with no idle bit between the two frames.
- R9: On the edge that ends the last stop bit, `done_o` goes to 1 for exactly one cycle. At the same edge `busy_o` falls, unless a held word starts.
- R10: Changing `bit_div_i` while a frame is being sent does not change the bit period of that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Setpoint load strobe |
| data_i | input | 16 | Signed setpoint word; bit 15 is the sign |
| bit_div_i | input | 8 | Clock cycles per serial bit |
| line_o | output | 1 | Serial line to the external driver, idle high |
| busy_o | output | 1 | A frame is being shifted out |
| done_o | output | 1 | One-cycle pulse at the end of each frame |

## Verification
The bench checks every cycle of every frame, not only bit centres. A divider that is off by one therefore shows up as a bit sliding into its neighbour. It uses payloads whose two bytes have odd and even weight in different combinations, so parity that is swapped, inverted or computed over the whole word produces a wrong bit in position 19 or 20.

Dividers of 0 and 1 are sent and must produce 2-cycle bits; a design without the clamp would stall or shift every cycle. A frame is loaded twice while busy, with the divider changed in the middle. A block that drops the held word, keeps the first strobe instead of the later one, inserts an idle bit, or re-reads the divider mid-frame then produces wrong data or wrong bit timing. Reset in the middle of a frame must force the line high at once and leave no held word behind.

// File: rtl/setpoint_tx_pkg.sv
package setpoint_tx_pkg;
  localparam int PAR_BITS = 2;
  localparam int MIN_DIV  = 2;

  function automatic int frame_width(input int data_w, input int sync_w);
    return 2 * sync_w + data_w + PAR_BITS;
  endfunction
endpackage

// File: rtl/setpoint_frame_builder.sv
module setpoint_frame_builder import setpoint_tx_pkg::*; #(
  parameter int DATA_W = 16,
  parameter int SYNC_W = 2,
  localparam int FRAME_W = frame_width(DATA_W, SYNC_W),
  localparam int HALF_W  = DATA_W / 2
) (
  input  logic [DATA_W-1:0]  data_i,
  output logic [FRAME_W-1:0] frame_o
);
  logic par_hi, par_lo;

  // even parity per half word
  assign par_hi = ^data_i[DATA_W-1:HALF_W];
  assign par_lo = ^data_i[HALF_W-1:0];

  // MSB of frame_o is the first bit on the line
  assign frame_o = {{SYNC_W{1'b0}}, data_i, par_hi, par_lo, {SYNC_W{1'b1}}};
endmodule

// File: rtl/setpoint_bit_timer.sv
module setpoint_bit_timer import setpoint_tx_pkg::*; #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q, div_q, div_eff;

  assign div_eff = (div_i < DIV_W'(MIN_DIV)) ? DIV_W'(MIN_DIV) : div_i;
  assign tick_o  = run_i && (cnt_q == div_q - DIV_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      div_q <= DIV_W'(MIN_DIV);
    end else if (start_i) begin
      cnt_q <= '0;
      div_q <= div_eff;  // period frozen for the whole frame
    end else if (run_i) begin
      cnt_q <= tick_o ? '0 : cnt_q + DIV_W'(1);
    end
  end
endmodule

// File: rtl/setpoint_frame_tx.sv
module setpoint_frame_tx import setpoint_tx_pkg::*; #(
  parameter int DATA_W = 16,
  parameter int SYNC_W = 2,
  parameter int DIV_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DIV_W-1:0]  bit_div_i,
  output logic              line_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int FRAME_W = frame_width(DATA_W, SYNC_W);
  localparam int CNT_W   = $clog2(FRAME_W);

  logic [FRAME_W-1:0] sh_q, frame;
  logic [CNT_W-1:0]   bit_cnt_q;
  logic [DATA_W-1:0]  pend_data_q, start_data;
  logic               busy_q, done_q, pend_q;
  logic               tick, last_bit, start;

  assign last_bit   = tick && (bit_cnt_q == CNT_W'(FRAME_W - 1));
  assign start      = (!busy_q && load_i) || (last_bit && (pend_q || load_i));
  assign start_data = load_i ? data_i : pend_data_q;

  setpoint_frame_builder #(.DATA_W(DATA_W), .SYNC_W(SYNC_W)) u_build (
    .data_i  (start_data),
    .frame_o (frame)
  );

  setpoint_bit_timer #(.DIV_W(DIV_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .run_i   (busy_q),
    .div_i   (bit_div_i),
    .tick_o  (tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q        <= '1;
      bit_cnt_q   <= '0;
      busy_q      <= 1'b0;
      done_q      <= 1'b0;
      pend_q      <= 1'b0;
      pend_data_q <= '0;
    end else begin
      done_q <= last_bit;
      if (start) begin
        sh_q      <= frame;
        bit_cnt_q <= '0;
        busy_q    <= 1'b1;
        pend_q    <= 1'b0;
      end else begin
        if (tick) begin
          sh_q      <= {sh_q[FRAME_W-2:0], 1'b1};
          bit_cnt_q <= bit_cnt_q + CNT_W'(1);
        end
        if (last_bit) busy_q <= 1'b0;
        // single holding slot, latest strobe wins
        if (busy_q && load_i) begin
          pend_q      <= 1'b1;
          pend_data_q <= data_i;
        end
      end
    end
  end

  assign line_o = busy_q ? sh_q[FRAME_W-1] : 1'b1;
  assign busy_o = busy_q;
  assign done_o = done_q;
endmodule

// File: rtl/setpoint_frame_tx_check.sv
module setpoint_frame_tx_check (
  input logic clk_i,
  input logic rst_ni,
  input logic line_o,
  input logic busy_o,
  input logic done_o,
  input logic tick_i
);
  assert_idle_high_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> line_o);

  assert_start_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !line_o);

  assert_stop_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(line_o));

  assert_bit_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && !$past(tick_i)) |-> $stable(line_o));

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_busy_end_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  assert_done_after_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(busy_o));
endmodule

bind setpoint_frame_tx setpoint_frame_tx_check u_check (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .line_o (line_o),
  .busy_o (busy_o),
  .done_o (done_o),
  .tick_i (tick)
);

// File: tb/setpoint_frame_tx_test.sv
module setpoint_frame_tx_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        load_i = 1'b0;
  logic [15:0] data_i = '0;
  logic [7:0]  bit_div_i = 8'd4;
  logic        line_o, busy_o, done_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  setpoint_frame_tx uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .data_i(data_i),
    .bit_div_i(bit_div_i), .line_o(line_o), .busy_o(busy_o), .done_o(done_o)
  );

  // {data, parity hi/lo, divider}
  localparam logic [25:0] VEC [0:6] = '{
    {16'h0000, 2'b00, 8'd4},
    {16'hFFFF, 2'b00, 8'd3},
    {16'h8001, 2'b11, 8'd40},
    {16'h7FFF, 2'b10, 8'd1},
    {16'h0103, 2'b10, 8'd0},
    {16'hA5C3, 2'b00, 8'd5},
    {16'h1234, 2'b01, 8'd2}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic start_load(input logic [15:0] d, input logic [7:0] div);
    @(negedge clk_i);
    data_i = d; bit_div_i = div; load_i = 1'b1;
  endtask

  // follows one frame cycle by cycle; the call starts just before the start edge
  task automatic walk(input logic [15:0] d, input logic [1:0] par, input int div,
                      output logic first_done);
    logic [21:0] f;
    int eff;
    string tag;
    f = {2'b00, d, par, 2'b11};
    eff = (div < 2) ? 2 : div;
    tag = (div < 2) ? "R3/R5/R6" : "R3/R5";
    first_done = 1'b0;
    for (int k = 0; k < 22; k++) begin
      bit bad = 0;
      int bad_val = 0;
      for (int c = 0; c < eff; c++) begin
        @(negedge clk_i);
        if (k == 0 && c == 0) begin
          load_i = 1'b0;
          first_done = done_o;
          chk(busy_o == 1'b1, "R7/R8 busy", busy_o, 1);
        end
        if ((line_o !== f[21-k] || busy_o !== 1'b1) && !bad) begin
          bad = 1; bad_val = {busy_o, line_o};
        end
      end
      chk(!bad, $sformatf("%s bit %0d", tag, k), bad_val, {1'b1, f[21-k]});
    end
  endtask

  task automatic check_end;
    @(negedge clk_i);
    chk(done_o == 1'b1, "R9 done", done_o, 1);
    chk(busy_o == 1'b0, "R9 busy", busy_o, 0);
    chk(line_o == 1'b1, "R2 idle", line_o, 1);
    @(negedge clk_i);
    chk(done_o == 1'b0, "R9 pulse", done_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic fd;
    // R1 reset state
    repeat (2) @(negedge clk_i);
    chk(line_o == 1'b1 && busy_o == 1'b0 && done_o == 1'b0, "R1 reset",
        {busy_o, line_o, done_o}, 3'b010);
    rst_ni = 1'b1;

    // R2 idle with moving inputs
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_i);
      data_i = 16'h1357 * i; bit_div_i = 8'(i);
      chk(line_o == 1'b1 && busy_o == 1'b0, "R2 idle", {busy_o, line_o}, 2'b01);
    end

    // vector table (R3 R4 R5 R6 R7 R9)
    for (int i = 0; i < 7; i++) begin
      start_load(VEC[i][25:10], VEC[i][7:0]);
      walk(VEC[i][25:10], VEC[i][9:8], int'(VEC[i][7:0]), fd);
      check_end();
    end

    // R8 R10: two strobes while busy, divider changed mid-frame
    start_load(16'h00F0, 8'd4);
    fork
      walk(16'h00F0, 2'b00, 4, fd);
      begin
        repeat (9) @(negedge clk_i);
        load_i = 1'b1; data_i = 16'h1111; bit_div_i = 8'd9;
        @(negedge clk_i);
        data_i = 16'h0C31;
        @(negedge clk_i);
        load_i = 1'b0; bit_div_i = 8'd3;
      end
    join
    walk(16'h0C31, 2'b01, 3, fd);
    chk(fd == 1'b1, "R8 R9 done between chained frames", fd, 1);
    check_end();

    // R1 reset mid-frame
    start_load(16'h5555, 8'd6);
    @(negedge clk_i);
    load_i = 1'b1; data_i = 16'h2222;  // held word to be discarded
    repeat (20) @(negedge clk_i);
    load_i = 1'b0;
    rst_ni = 1'b0;
    #1;
    chk(line_o == 1'b1 && busy_o == 1'b0 && done_o == 1'b0, "R1 async reset",
        {busy_o, line_o, done_o}, 3'b010);
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk_i);
      if (busy_o || !line_o) begin
        chk(1'b0, "R1 held word dropped", {busy_o, line_o}, 2'b01);
        break;
      end
    end
    chk(busy_o == 1'b0 && line_o == 1'b1, "R1 idle after reset", {busy_o, line_o}, 2'b01);

    // frame after reset
    start_load(16'h8000, 8'd2);
    walk(16'h8000, 2'b10, 2, fd);
    check_end();

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule